// File: doc/BRIEF.md
# I2C EEPROM Boot-Load Sequencer

This block runs once after reset and configures a chip from a serial EEPROM. It waits for the I2C bus to go idle, addresses the EEPROM, reads an 8-byte header from memory location zero and then copies a list of 8-byte records into an internal 32-bit register bus. Each record gives a register address and a data word, and the block issues one write per record. It never drives the I2C wires itself. It sends byte-level commands to a separate I2C master and acts on the completion, acknowledge, arbitration-lost and read-data results that the master returns.

The device address is `{5'b10100, strap}`. The 2-bit strap is captured while reset is held, so up to four chips can share one bus while each boots from its own EEPROM. If the EEPROM answers the address with NACK, the block releases the bus and tries again, up to a fixed number of attempts. Once the EEPROM has acknowledged, the block keeps the bus until the end of the load and uses repeated STARTs to re-address the EEPROM. The result of the load is reported through two sticky status bits, OK and FAIL, each with its own interrupt enable, and both can be cleared by writing a one.

Top module: `i2c_boot_loader`

## Requirements
- R1: The device address sent is `{5'b10100, s}`, where `s` is the value on `strap_sel` during the last clock edge with `rst` high. Later changes on `strap_sel` have no effect.
- R2: The block issues no command until `bus_idle` is high. If START or the first device-address write reports arbitration loss, the block goes back to waiting for idle, and that attempt is not counted as a NACK.
- R3: If the device-address write reports NACK during detection, the block issues STOP and retries from wait-for-idle. On the sixth NACK it issues STOP and sets FAIL, and no register writes occur.
- R4: After the device acknowledges detection, the block issues only RESTART (`cmd_op`=1) to re-address the device, and it issues exactly one STOP (`cmd_op`=2), at the end of the load.
- R5: The header is read starting at EEPROM address 0, which is written most-significant byte first over `ADDR_BYTES` bytes. Header bytes 0 and 1 form the count, high byte first. If any of header bytes 2 to 7 is not 0xFF, the load ends with STOP and FAIL.
- R6: A count greater than `MAX_REGS` ends the load with FAIL. A count equal to `MAX_REGS` is accepted.
- R7: A count of zero ends the load with STOP and OK, and no register writes occur.
- R8: Each record is 8 bytes at EEPROM address 8+8k: a 32-bit address followed by 32-bit data, each high byte first. Exactly one single-cycle `reg_wr_en` pulse is issued per record, after all 8 bytes have arrived, and records are written in order.
- R9: After the last record, the block issues STOP and sets OK. OK and FAIL are never both set.
- R10: Every read (`cmd_op`=4) has `cmd_rd_nack` high only for the eighth byte of each 8-byte burst.
- R11: OK and FAIL are sticky. `sts_clr` bit 0 clears OK and bit 1 clears FAIL. A set that falls in the same cycle as a clear wins.
- R12: `irq_ok` equals `sts_ok & irq_ok_en`, and `irq_fail` equals `sts_fail & irq_fail_en`, both registered. A change of enable is seen one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; strap captured while high |
| strap_sel | input | 2 | Low two bits of the device address |
| bus_idle | input | 1 | I2C master reports bus idle |
| mst_done | input | 1 | One-cycle completion pulse for the pending command |
| mst_ack | input | 1 | Slave acknowledged the written byte |
| mst_arb_lost | input | 1 | Arbitration lost during the command |
| mst_rdata | input | 8 | Byte returned by a read command |
| cmd_valid | output | 1 | One-cycle command issue pulse |
| cmd_op | output | 3 | 0 START, 1 RESTART, 2 STOP, 3 WRITE, 4 READ |
| cmd_data | output | 8 | Byte for WRITE |
| cmd_rd_nack | output | 1 | Answer the READ byte with NACK |
| reg_wr_en | output | 1 | Register-bus write strobe |
| reg_wr_addr | output | 32 | Register-bus address |
| reg_wr_data | output | 32 | Register-bus data |
| irq_ok_en | input | 1 | Interrupt enable for OK |
| irq_fail_en | input | 1 | Interrupt enable for FAIL |
| sts_clr | input | 2 | Write-one-to-clear: bit 0 OK, bit 1 FAIL |
| sts_ok | output | 1 | Sticky load-succeeded status |
| sts_fail | output | 1 | Sticky load-aborted status |
| irq_ok | output | 1 | OK interrupt |
| irq_fail | output | 1 | FAIL interrupt |

## Verification
The end of a successful load sets OK, and software may clear OK with a write-one in that same cycle. The bench forces the two to meet: it drives `sts_clr` = 2'b11 in the cycle right after the master completes the final STOP, which is the cycle in which the OK set pulse reaches the status register. The check passes only if OK is still high afterwards. A clear issued one cycle later must then drop OK and its interrupt, while a clear of OK alone must leave FAIL unchanged.

// File: rtl/i2cboot_pkg.sv
package i2cboot_pkg;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_RESTART = 3'd1,
    OP_STOP    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_READ    = 3'd4
  } bus_op_e;

  typedef enum logic [3:0] {
    S_WAIT, S_START, S_DEVW, S_ADDR, S_RESTART,
    S_DEVR, S_READ, S_EVAL, S_STOP, S_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    END_RETRY, END_FAIL, END_OK
  } end_kind_e;

  localparam logic [4:0] DEV_UPPER = 5'b10100;
  localparam int         STRAP_W   = 2;
  localparam int         BURST     = 8;

endpackage

// File: rtl/boot_dev_addr.sv
module boot_dev_addr
  import i2cboot_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap,
  output logic [6:0]         dev_addr
);
  logic [STRAP_W-1:0] strap_q;

  // captured continuously while reset is held, frozen at release
  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap;
  end

  assign dev_addr = {DEV_UPPER, strap_q};
endmodule

// File: rtl/boot_rec_shift.sv
module boot_rec_shift #(
  parameter int BYTES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic [7:0]         din,
  output logic [BYTES*8-1:0] rec
);
  localparam int W = BYTES * 8;

  // bytes enter at the bottom, so the first byte ends up most significant
  always_ff @(posedge clk) begin
    if (rst)           rec <= '0;
    else if (shift_en) rec <= {rec[W-9:0], din};
  end
endmodule

// File: rtl/boot_status.sv
module boot_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_ok,
  input  logic       set_fail,
  input  logic [1:0] clr,
  input  logic       en_ok,
  input  logic       en_fail,
  output logic       sts_ok,
  output logic       sts_fail,
  output logic       irq_ok,
  output logic       irq_fail
);
  logic ok_n, fail_n;

  always_comb begin
    ok_n   = set_ok   | (sts_ok   & ~clr[0]);
    fail_n = set_fail | (sts_fail & ~clr[1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_ok   <= 1'b0;
      sts_fail <= 1'b0;
      irq_ok   <= 1'b0;
      irq_fail <= 1'b0;
    end else begin
      sts_ok   <= ok_n;
      sts_fail <= fail_n;
      irq_ok   <= ok_n & en_ok;
      irq_fail <= fail_n & en_fail;
    end
  end
endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import i2cboot_pkg::*;
#(
  parameter int MAX_REGS   = 1024,
  parameter int RETRIES    = 6,
  parameter int ADDR_BYTES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [6:0]  dev_addr,
  input  logic        bus_idle,
  input  logic        mst_done,
  input  logic        mst_ack,
  input  logic        mst_arb_lost,
  input  logic [63:0] rec,
  output logic        cmd_valid,
  output logic [2:0]  cmd_op,
  output logic [7:0]  cmd_data,
  output logic        cmd_rd_nack,
  output logic        shift_en,
  output logic        wr_en,
  output logic [31:0] wr_addr,
  output logic [31:0] wr_data,
  output logic        set_ok,
  output logic        set_fail
);
  localparam int CNT_W = $clog2(MAX_REGS + 1);
  localparam int RTY_W = $clog2(RETRIES + 1);
  localparam int PTR_W = ADDR_BYTES * 8;
  localparam int IDX_W = $clog2(BURST);

  seq_state_e       state;
  end_kind_e        end_kind;
  logic             pend, hunting, to_read, header;
  logic [IDX_W-1:0] idx;
  logic [RTY_W-1:0] nack_cnt;
  logic [CNT_W-1:0] remaining;
  logic [PTR_W-1:0] ptr;

  logic             is_cmd, fin;
  bus_op_e          op_c;
  logic [7:0]       data_c;
  logic [PTR_W-1:0] ptr_sh;
  logic [15:0]      hdr_cnt;
  logic             filler_ok, cnt_big;

  assign ptr_sh    = ptr >> (8 * (ADDR_BYTES - 1 - int'(idx)));
  assign hdr_cnt   = rec[63:48];
  assign filler_ok = &rec[47:0];
  assign cnt_big   = {1'b0, hdr_cnt} > 17'(MAX_REGS);
  assign fin       = pend & mst_done;
  assign shift_en  = fin && (state == S_READ);

  always_comb begin
    is_cmd = 1'b1;
    op_c   = OP_WRITE;
    data_c = 8'h00;
    case (state)
      S_START:   op_c   = OP_START;
      S_DEVW:    data_c = {dev_addr, 1'b0};
      S_ADDR:    data_c = ptr_sh[7:0];
      S_RESTART: op_c   = OP_RESTART;
      S_DEVR:    data_c = {dev_addr, 1'b1};
      S_READ:    op_c   = OP_READ;
      S_STOP:    op_c   = OP_STOP;
      default:   is_cmd = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_WAIT;
      end_kind    <= END_OK;
      pend        <= 1'b0;
      hunting     <= 1'b1;
      to_read     <= 1'b0;
      header      <= 1'b1;
      idx         <= '0;
      nack_cnt    <= '0;
      remaining   <= '0;
      ptr         <= '0;
      cmd_valid   <= 1'b0;
      cmd_op      <= 3'd0;
      cmd_data    <= 8'h00;
      cmd_rd_nack <= 1'b0;
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      set_ok      <= 1'b0;
      set_fail    <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      wr_en     <= 1'b0;
      set_ok    <= 1'b0;
      set_fail  <= 1'b0;
      if (is_cmd && !pend) begin
        cmd_valid   <= 1'b1;
        cmd_op      <= op_c;
        cmd_data    <= data_c;
        cmd_rd_nack <= (idx == IDX_W'(BURST - 1));
        pend        <= 1'b1;
      end else if (fin) begin
        pend <= 1'b0;
        if (mst_arb_lost && state != S_STOP) begin
          if (hunting) state <= S_WAIT;
          else begin
            set_fail <= 1'b1;
            state    <= S_DONE;
          end
        end else begin
          case (state)
            S_START: state <= S_DEVW;
            S_DEVW: begin
              if (!mst_ack) begin
                state <= S_STOP;
                if (hunting) begin
                  nack_cnt <= nack_cnt + 1'b1;
                  end_kind <= (nack_cnt == RTY_W'(RETRIES - 1)) ? END_FAIL : END_RETRY;
                end else end_kind <= END_FAIL;
              end else begin
                hunting <= 1'b0;
                idx     <= '0;
                state   <= S_ADDR;
              end
            end
            S_ADDR: begin
              if (!mst_ack) begin
                end_kind <= END_FAIL;
                state    <= S_STOP;
              end else if (idx == IDX_W'(ADDR_BYTES - 1)) begin
                idx     <= '0;
                to_read <= 1'b1;
                state   <= S_RESTART;
              end else idx <= idx + 1'b1;
            end
            S_RESTART: state <= to_read ? S_DEVR : S_DEVW;
            S_DEVR: begin
              if (!mst_ack) begin
                end_kind <= END_FAIL;
                state    <= S_STOP;
              end else begin
                idx   <= '0;
                state <= S_READ;
              end
            end
            S_READ: begin
              if (idx == IDX_W'(BURST - 1)) begin
                idx   <= '0;
                state <= S_EVAL;
              end else idx <= idx + 1'b1;
            end
            S_STOP: begin
              case (end_kind)
                END_RETRY: state <= S_WAIT;
                END_FAIL: begin
                  set_fail <= 1'b1;
                  state    <= S_DONE;
                end
                default: begin
                  set_ok <= 1'b1;
                  state  <= S_DONE;
                end
              endcase
            end
            default: ;
          endcase
        end
      end else if (state == S_WAIT) begin
        if (bus_idle) state <= S_START;
      end else if (state == S_EVAL) begin
        if (header) begin
          if (!filler_ok || cnt_big) begin
            end_kind <= END_FAIL;
            state    <= S_STOP;
          end else if (hdr_cnt == 16'd0) begin
            end_kind <= END_OK;
            state    <= S_STOP;
          end else begin
            remaining <= CNT_W'(hdr_cnt);
            header    <= 1'b0;
            ptr       <= ptr + PTR_W'(BURST);
            to_read   <= 1'b0;
            state     <= S_RESTART;
          end
        end else begin
          wr_en     <= 1'b1;
          wr_addr   <= rec[63:32];
          wr_data   <= rec[31:0];
          remaining <= remaining - 1'b1;
          ptr       <= ptr + PTR_W'(BURST);
          if (remaining == CNT_W'(1)) begin
            end_kind <= END_OK;
            state    <= S_STOP;
          end else begin
            to_read <= 1'b0;
            state   <= S_RESTART;
          end
        end
      end
    end
  end
endmodule

// File: rtl/i2c_boot_loader.sv
module i2c_boot_loader
  import i2cboot_pkg::*;
#(
  parameter int MAX_REGS   = 1024,
  parameter int RETRIES    = 6,
  parameter int ADDR_BYTES = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  strap_sel,
  input  logic        bus_idle,
  input  logic        mst_done,
  input  logic        mst_ack,
  input  logic        mst_arb_lost,
  input  logic [7:0]  mst_rdata,
  output logic        cmd_valid,
  output logic [2:0]  cmd_op,
  output logic [7:0]  cmd_data,
  output logic        cmd_rd_nack,
  output logic        reg_wr_en,
  output logic [31:0] reg_wr_addr,
  output logic [31:0] reg_wr_data,
  input  logic        irq_ok_en,
  input  logic        irq_fail_en,
  input  logic [1:0]  sts_clr,
  output logic        sts_ok,
  output logic        sts_fail,
  output logic        irq_ok,
  output logic        irq_fail
);
  logic [6:0]  dev_addr;
  logic [63:0] rec;
  logic        shift_en, set_ok, set_fail;

  boot_dev_addr u_dev (
    .clk(clk), .rst(rst), .strap(strap_sel), .dev_addr(dev_addr)
  );

  boot_rec_shift #(.BYTES(BURST)) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .din(mst_rdata), .rec(rec)
  );

  boot_seq #(
    .MAX_REGS(MAX_REGS), .RETRIES(RETRIES), .ADDR_BYTES(ADDR_BYTES)
  ) u_seq (
    .clk(clk), .rst(rst), .dev_addr(dev_addr), .bus_idle(bus_idle),
    .mst_done(mst_done), .mst_ack(mst_ack), .mst_arb_lost(mst_arb_lost),
    .rec(rec), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_rd_nack(cmd_rd_nack), .shift_en(shift_en), .wr_en(reg_wr_en),
    .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .set_ok(set_ok), .set_fail(set_fail)
  );

  boot_status u_sts (
    .clk(clk), .rst(rst), .set_ok(set_ok), .set_fail(set_fail),
    .clr(sts_clr), .en_ok(irq_ok_en), .en_fail(irq_fail_en),
    .sts_ok(sts_ok), .sts_fail(sts_fail), .irq_ok(irq_ok), .irq_fail(irq_fail)
  );
endmodule

// File: rtl/boot_checker.sv
module boot_checker (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       reg_wr_en,
  input logic [1:0] sts_clr,
  input logic       sts_ok,
  input logic       sts_fail,
  input logic       irq_ok,
  input logic       irq_fail
);
  assert_irq_ok_R12: assert property (@(posedge clk) disable iff (rst)
    irq_ok |-> sts_ok);

  assert_irq_fail_R12: assert property (@(posedge clk) disable iff (rst)
    irq_fail |-> sts_fail);

  assert_ok_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (sts_ok && !sts_clr[0]) |=> sts_ok);

  assert_fail_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (sts_fail && !sts_clr[1]) |=> sts_fail);

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
    !(sts_ok && sts_fail));

  assert_wr_single_R8: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> !reg_wr_en);

  assert_cmd_single_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
endmodule

bind i2c_boot_loader boot_checker u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .reg_wr_en(reg_wr_en),
  .sts_clr(sts_clr), .sts_ok(sts_ok), .sts_fail(sts_fail),
  .irq_ok(irq_ok), .irq_fail(irq_fail)
);

// File: tb/sim_i2c_boot_loader.sv
`timescale 1ns/1ps
module sim_i2c_boot_loader;
  localparam int MAXR = 4;
  localparam int NROW = 8;
  // {strap[31:30], nacks[29:26], arbs[25:24], count[23:8], bad[7], ok[6], fail[5], writes[4:0]}
  localparam logic [31:0] ROWS [NROW] = '{
    {2'd0, 4'd0, 2'd0, 16'd2, 1'b0, 1'b1, 1'b0, 5'd2},
    {2'd3, 4'd5, 2'd0, 16'd1, 1'b0, 1'b1, 1'b0, 5'd1},
    {2'd1, 4'd6, 2'd0, 16'd1, 1'b0, 1'b0, 1'b1, 5'd0},
    {2'd2, 4'd0, 2'd2, 16'd0, 1'b0, 1'b1, 1'b0, 5'd0},
    {2'd0, 4'd0, 2'd0, 16'd5, 1'b0, 1'b0, 1'b1, 5'd0},
    {2'd1, 4'd0, 2'd0, 16'd4, 1'b0, 1'b1, 1'b0, 5'd4},
    {2'd2, 4'd0, 2'd0, 16'd1, 1'b1, 1'b0, 1'b1, 5'd0},
    {2'd3, 4'd5, 2'd2, 16'd3, 1'b0, 1'b1, 1'b0, 5'd3}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] strap_sel = 2'd0;
  logic bus_idle = 1'b1, mst_done = 1'b0, mst_ack = 1'b0, mst_arb_lost = 1'b0;
  logic [7:0] mst_rdata = 8'h00;
  logic cmd_valid, cmd_rd_nack, reg_wr_en;
  logic [2:0] cmd_op;
  logic [7:0] cmd_data;
  logic [31:0] reg_wr_addr, reg_wr_data;
  logic irq_ok_en = 1'b1, irq_fail_en = 1'b1;
  logic [1:0] sts_clr = 2'b00;
  logic sts_ok, sts_fail, irq_ok, irq_fail;

  always #10 clk = ~clk;

  i2c_boot_loader #(.MAX_REGS(MAXR)) u0 (.*);

  int checks = 0, fails = 0;
  logic [7:0] mem [64];
  logic [1:0] strap_ref;
  int nack_left, arb_left, starts, stops_after, bad_dev, rd_err, rd_cnt, wr_seen, wr_err, cmds;
  bit det_ok, expect_dev, race;
  logic [15:0] m_ptr;

  function automatic logic [31:0] rec_addr(input int k);
    return 32'h4000_0000 + 32'(k) * 32'h0000_0104;
  endfunction
  function automatic logic [31:0] rec_data(input int k);
    return 32'hC0DE_5A00 ^ (32'(k) * 32'h0103_0507);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // I2C master + EEPROM model
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_valid) begin
        logic [2:0] op;
        logic [7:0] d;
        logic nk;
        op = cmd_op; d = cmd_data; nk = cmd_rd_nack; cmds++;
        repeat (2) @(negedge clk);
        mst_ack = 1'b0; mst_arb_lost = 1'b0;
        case (op)
          3'd0: begin
            starts++; expect_dev = 1'b1;
            if (arb_left > 0) begin arb_left--; mst_arb_lost = 1'b1; end
          end
          3'd1: expect_dev = 1'b1;
          3'd2: if (det_ok) stops_after++;
          3'd3: begin
            if (expect_dev) begin
              expect_dev = 1'b0;
              if (d[7:1] != {5'b10100, strap_ref}) begin bad_dev++; mst_ack = 1'b0; end
              else if (!d[0] && !det_ok && nack_left > 0) begin nack_left--; mst_ack = 1'b0; end
              else begin
                mst_ack = 1'b1;
                if (!d[0]) det_ok = 1'b1;
                else rd_cnt = 0;
              end
            end else begin
              m_ptr = {m_ptr[7:0], d};
              mst_ack = 1'b1;
            end
          end
          default: begin
            mst_rdata = mem[m_ptr[5:0]];
            m_ptr++;
            rd_cnt++;
            if (nk != (rd_cnt == 8)) rd_err++;
          end
        endcase
        mst_done = 1'b1;
        @(negedge clk);
        mst_done = 1'b0;
        if (op == 3'd2 && race && det_ok) begin
          sts_clr = 2'b11;
          @(negedge clk);
          sts_clr = 2'b00;
        end
      end
    end
  end

  // register-bus monitor (R8)
  initial begin
    forever begin
      @(negedge clk);
      if (reg_wr_en) begin
        if (reg_wr_addr != rec_addr(wr_seen) || reg_wr_data != rec_data(wr_seen)) wr_err++;
        wr_seen++;
      end
    end
  end

  task automatic run_case(input logic [1:0] s, input int nacks, input int arbs,
                          input logic [15:0] cnt, input bit bad, input bit rc);
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    mem[0] = cnt[15:8]; mem[1] = cnt[7:0];
    for (int i = 2; i < 8; i++) mem[i] = 8'hFF;
    if (bad) mem[4] = 8'hF7;
    for (int k = 0; k < 7 && k < int'(cnt); k++) begin
      for (int b = 0; b < 4; b++) begin
        mem[8 + 8*k + b]     = rec_addr(k) >> (24 - 8*b);
        mem[8 + 8*k + 4 + b] = rec_data(k) >> (24 - 8*b);
      end
    end
    rst = 1'b1; strap_sel = s;
    repeat (3) @(negedge clk);
    nack_left = nacks; arb_left = arbs; starts = 0; stops_after = 0; bad_dev = 0;
    rd_err = 0; rd_cnt = 0; wr_seen = 0; wr_err = 0; cmds = 0;
    det_ok = 1'b0; expect_dev = 1'b0; race = rc; m_ptr = 16'h0;
    strap_ref = s;
    rst = 1'b0; strap_sel = ~s;
    begin
      int n = 0;
      while (!(sts_ok || sts_fail) && n < 20000) begin @(negedge clk); n++; end
      if (n >= 20000) begin fails++; $display("FAIL R9 run timeout actual=hung expected=done"); end
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    // reset state and wait-for-idle (R11, R12, R2)
    rst = 1'b1; bus_idle = 1'b0;
    repeat (3) @(negedge clk);
    chk(!sts_ok && !sts_fail, "R11 reset status clear", {sts_ok, sts_fail}, 0);
    chk(!irq_ok && !irq_fail, "R12 reset irq low", {irq_ok, irq_fail}, 0);
    cmds = 0; rst = 1'b0;
    repeat (20) @(negedge clk);
    chk(cmds == 0 && !cmd_valid, "R2 no command while bus busy", cmds, 0);
    bus_idle = 1'b1;

    for (int r = 0; r < NROW; r++) begin
      logic [31:0] v;
      int nk, ab, exp_starts;
      v = ROWS[r];
      nk = int'(v[29:26]); ab = int'(v[25:24]);
      run_case(v[31:30], nk, ab, v[23:8], v[7], 1'b0);
      exp_starts = ab + ((nk >= 6) ? 6 : nk + 1);
      chk(sts_ok == v[6], "R9 R7 ok status per vector", sts_ok, v[6]);
      chk(sts_fail == v[5], "R3 R5 R6 fail status per vector", sts_fail, v[5]);
      chk(wr_seen == int'(v[4:0]), "R8 write count", wr_seen, v[4:0]);
      chk(wr_err == 0, "R8 record address/data order", wr_err, 0);
      chk(bad_dev == 0, "R1 device address from reset strap", bad_dev, 0);
      chk(rd_err == 0, "R10 read ACK/NACK pattern", rd_err, 0);
      chk(starts == exp_starts, "R2 R3 START attempts", starts, exp_starts);
      if (det_ok) chk(stops_after == 1, "R4 single STOP after detection", stops_after, 1);
      chk(irq_ok == sts_ok && irq_fail == sts_fail, "R12 irq follows status", {irq_ok, irq_fail}, {sts_ok, sts_fail});
    end

    // set and clear in the same cycle (R11), then plain clear
    run_case(2'd1, 0, 0, 16'd2, 1'b0, 1'b1);
    chk(sts_ok == 1'b1, "R11 set wins over same-cycle clear", sts_ok, 1);
    sts_clr = 2'b01;
    @(negedge clk);
    sts_clr = 2'b00;
    chk(sts_ok == 1'b0 && irq_ok == 1'b0, "R11 R12 W1C clears ok", {sts_ok, irq_ok}, 0);

    // fail with interrupt masked, then enabled (R12), clear separation (R11)
    irq_fail_en = 1'b0;
    run_case(2'd2, 0, 0, 16'd1, 1'b1, 1'b0);
    chk(sts_fail && !irq_fail, "R12 masked fail irq", {sts_fail, irq_fail}, 2'b10);
    irq_fail_en = 1'b1;
    @(negedge clk);
    chk(irq_fail == 1'b1, "R12 enable seen next cycle", irq_fail, 1);
    sts_clr = 2'b01;
    @(negedge clk);
    sts_clr = 2'b00;
    chk(sts_fail == 1'b1, "R11 ok clear leaves fail", sts_fail, 1);
    sts_clr = 2'b10;
    @(negedge clk);
    sts_clr = 2'b00;
    chk(sts_fail == 1'b0 && irq_fail == 1'b0, "R11 fail clear", {sts_fail, irq_fail}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule